// File: doc/BRIEF.md
# Floating-point control and status register

This block holds the rounding-mode and sticky exception-flag state of a scalar floating-point unit. Software reaches it through three aliased views of one 32-bit word: the whole word, the 3-bit rounding field alone, or the 5-bit flag field alone. Each request either reads the selected view or swaps it. A swap returns the value held before the operation and installs the new value at the next clock edge.

Alongside software access, the floating-point datapath presents newly raised exception conditions on a separate accrual port. Those bits are ORed into the flags, so a flag stays set until software overwrites it. The stored rounding mode is driven out continuously, together with an indication of whether it is an encoding that cannot be used.

Top module: `fp_status_ctl`

## Requirements
- R1: After a synchronous active-low reset, the rounding mode and all flags are zero, and `round_illegal` is low.
- R2: Full view (`req_view`=00) reads `{24'b0, mode[2:0], flags[4:0]}`. The flags sit in bits 4:0 (bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact) and the mode sits in bits 7:5. Bits 31:8 always read zero.
- R3: Rounding view (`req_view`=01) reads the mode in bits 2:0. Flag view (`req_view`=10) reads the flags in bits 4:0. All other bits read zero.
- R4: `rdata` shows the selected view of the state held now, and a swap (`req_swap`=1 with `req_valid`=1) takes effect at the next rising edge. A read (`req_swap`=0) changes nothing.
- R5: A rounding-view swap writes `wdata[2:0]` to the mode and leaves the flags unchanged.
- R6: A flag-view swap writes `wdata[4:0]` to the flags and leaves the mode unchanged.
- R7: A full-view swap writes `wdata[7:5]` to the mode and `wdata[4:0]` to the flags. `wdata[31:8]` is ignored.
- R8: When `acc_valid` is high, `acc_flags` is ORed into the flags at the next edge. When `acc_valid` is low, `acc_flags` has no effect.
- R9: If a swap writes the flags in the same cycle as an accrual, the stored flags become the written value ORed with the accrued bits.
- R10: `round_mode` always equals the stored mode. `round_illegal` is high exactly when that mode is 101, 110 or 111. The legal encodings are 000 nearest-even, 001 toward zero, 010 down, 011 up and 100 nearest-max-magnitude.
- R11: View code 11 reads as zero, and a swap on it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Software request this cycle |
| req_swap | input | 1 | 0 = read, 1 = swap |
| req_view | input | 2 | 00 full, 01 rounding, 10 flags, 11 unused |
| wdata | input | 32 | Swap write data |
| rdata | output | 32 | Selected view of the current state |
| acc_valid | input | 1 | Accrual strobe from the datapath |
| acc_flags | input | 5 | Newly raised exception flags |
| round_mode | output | 3 | Stored rounding mode |
| round_illegal | output | 1 | Stored mode is a reserved encoding |

## Verification
The bound checker examines every cycle for the following properties:
- Reserved read bits are zero.
- Each swap lands in its target field and nowhere else.
- Accrued bits stick.
- An idle cycle leaves the state untouched.
- The illegal-mode flag only rises for reserved modes.

The directed scenarios show what single-cycle properties cannot. These are the old value returned during a swap followed by the new value one edge later, the exact OR of a write colliding with an accrual, and the silence of the unused view across a full sequence of operations.

// File: rtl/fp_status_ctl.sv
module fp_status_ctl #(
  parameter int WORD_W = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_swap,
  input  logic [1:0]        req_view,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              acc_valid,
  input  logic [FLAG_W-1:0] acc_flags,
  output logic [RM_W-1:0]   round_mode,
  output logic              round_illegal
);
  localparam int          PAD_W      = WORD_W - FLAG_W - RM_W;
  localparam int          RM_LSB     = FLAG_W;
  localparam logic [1:0]  VIEW_FULL  = 2'd0;
  localparam logic [1:0]  VIEW_RM    = 2'd1;
  localparam logic [1:0]  VIEW_FLAGS = 2'd2;
  localparam logic [RM_W-1:0] RM_MAX_LEGAL = RM_W'(4);

  logic [FLAG_W-1:0] flags_q, flags_sw, flags_d;
  logic [RM_W-1:0]   rm_q, rm_d;
  logic              swap;

  assign swap = req_valid & req_swap;

  always_comb begin
    rm_d     = rm_q;
    flags_sw = flags_q;
    if (swap) begin
      case (req_view)
        VIEW_FULL: begin
          rm_d     = wdata[RM_LSB +: RM_W];
          flags_sw = wdata[FLAG_W-1:0];
        end
        VIEW_RM:    rm_d     = wdata[RM_W-1:0];
        VIEW_FLAGS: flags_sw = wdata[FLAG_W-1:0];
        default: ;
      endcase
    end
    flags_d = flags_sw | (acc_valid ? acc_flags : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rm_q    <= '0;
      flags_q <= '0;
    end else begin
      rm_q    <= rm_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    case (req_view)
      VIEW_FULL:  rdata = {{PAD_W{1'b0}}, rm_q, flags_q};
      VIEW_RM:    rdata = {{(WORD_W-RM_W){1'b0}}, rm_q};
      VIEW_FLAGS: rdata = {{(WORD_W-FLAG_W){1'b0}}, flags_q};
      default:    rdata = '0;
    endcase
  end

  assign round_mode    = rm_q;
  assign round_illegal = rm_q > RM_MAX_LEGAL;
endmodule

// File: rtl/fp_status_ctl_chk.sv
module fp_status_ctl_chk #(
  parameter int WORD_W = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_swap,
  input logic [1:0]        req_view,
  input logic [WORD_W-1:0] wdata,
  input logic [WORD_W-1:0] rdata,
  input logic              acc_valid,
  input logic [FLAG_W-1:0] acc_flags,
  input logic [RM_W-1:0]   round_mode,
  input logic              round_illegal,
  input logic [FLAG_W-1:0] flags_q
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[WORD_W-1:FLAG_W+RM_W] == '0);

  // R5
  rm_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_swap && req_view == 2'd1 && !acc_valid)
      |=> (round_mode == $past(wdata[RM_W-1:0])) && $stable(flags_q));

  // R6
  flag_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_swap && req_view == 2'd2 && !acc_valid)
      |=> (flags_q == $past(wdata[FLAG_W-1:0])) && $stable(round_mode));

  // R8
  accrue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ((flags_q & $past(acc_flags)) == $past(acc_flags)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_swap) && !acc_valid) |=> $stable(flags_q) && $stable(round_mode));

  // R10
  illegal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_illegal |-> round_mode[RM_W-1]);
endmodule

bind fp_status_ctl fp_status_ctl_chk #(.WORD_W(WORD_W), .FLAG_W(FLAG_W), .RM_W(RM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_swap(req_swap),
  .req_view(req_view), .wdata(wdata), .rdata(rdata), .acc_valid(acc_valid),
  .acc_flags(acc_flags), .round_mode(round_mode), .round_illegal(round_illegal),
  .flags_q(flags_q)
);

// File: tb/tb_fp_status_ctl.sv
module tb_fp_status_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_swap = 1'b0;
  logic [1:0]  req_view = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        acc_valid = 1'b0;
  logic [4:0]  acc_flags = '0;
  logic [2:0]  round_mode;
  logic        round_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  fp_status_ctl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_swap(req_swap),
    .req_view(req_view), .wdata(wdata), .rdata(rdata), .acc_valid(acc_valid),
    .acc_flags(acc_flags), .round_mode(round_mode), .round_illegal(round_illegal)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic peek(input logic [1:0] v, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b0;
    req_view  = v;
    #2 r = rdata;
  endtask

  task automatic op(input logic [1:0] v, input logic sw, input logic [31:0] wd,
                    input logic acc, input logic [4:0] af, output logic [31:0] old);
    @(negedge clk);
    req_valid = 1'b1; req_swap = sw; req_view = v; wdata = wd;
    acc_valid = acc;  acc_flags = af;
    #2 old = rdata;
    @(negedge clk);
    req_valid = 1'b0; req_swap = 1'b0; acc_valid = 1'b0; acc_flags = '0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    peek(2'd0, r);
    check("R1 full after reset", r, 32'h0);
    check("R1 illegal after reset", {31'b0, round_illegal}, 32'h0);
  endtask

  task automatic t_full_swap();
    logic [31:0] r, old;
    op(2'd0, 1'b1, 32'hFFFF_FFAB, 1'b0, 5'h0, old);
    check("R4 full swap old value", old, 32'h0);
    peek(2'd0, r);
    check("R7 full swap drops upper bits", r, 32'h0000_00AB);
    check("R10 round_mode after full swap", {29'b0, round_mode}, 32'h5);
    check("R10 illegal for 101", {31'b0, round_illegal}, 32'h1);
  endtask

  task automatic t_rm_swap();
    logic [31:0] r, old;
    op(2'd1, 1'b1, 32'hFFFF_FFF9, 1'b0, 5'h0, old);
    check("R5 rm swap old value", old, 32'h5);
    peek(2'd0, r);
    check("R5 rm swap low bits, flags kept", r, 32'h0000_002B);
    peek(2'd1, r);
    check("R3 rounding view", r, 32'h1);
    check("R10 legal 001", {31'b0, round_illegal}, 32'h0);
  endtask

  task automatic t_flag_swap();
    logic [31:0] r, old;
    op(2'd2, 1'b1, 32'hFFFF_FF34, 1'b0, 5'h0, old);
    check("R6 flag swap old value", old, 32'h0B);
    peek(2'd2, r);
    check("R3 flag view after R6 swap", r, 32'h14);
    check("R6 mode kept", {29'b0, round_mode}, 32'h1);
  endtask

  task automatic t_read_only();
    logic [31:0] r, old;
    op(2'd0, 1'b0, 32'hFFFF_FFFF, 1'b0, 5'h0, old);
    check("R4 read returns state", old, 32'h34);
    peek(2'd0, r);
    check("R4 read leaves state", r, 32'h34);
  endtask

  task automatic t_accrue();
    logic [31:0] r;
    @(negedge clk); acc_valid = 1'b1; acc_flags = 5'h01;
    @(negedge clk); acc_valid = 1'b0; acc_flags = 5'h1F;
    @(negedge clk); acc_flags = 5'h0;
    peek(2'd2, r);
    check("R8 accrual ORs, no strobe ignored", r, 32'h15);
  endtask

  task automatic t_collide();
    logic [31:0] r, old;
    op(2'd2, 1'b1, 32'h0, 1'b1, 5'h08, old);
    peek(2'd2, r);
    check("R9 write OR accrual", r, 32'h08);
  endtask

  task automatic t_unused_view();
    logic [31:0] r, old;
    op(2'd3, 1'b1, 32'hFFFF_FFFF, 1'b0, 5'h0, old);
    check("R11 unused view reads zero", old, 32'h0);
    peek(2'd0, r);
    check("R11 unused swap no effect", r, 32'h28);
  endtask

  task automatic t_modes();
    logic [31:0] old;
    op(2'd1, 1'b1, 32'h6, 1'b0, 5'h0, old);
    check("R10 illegal 110", {31'b0, round_illegal}, 32'h1);
    op(2'd1, 1'b1, 32'h7, 1'b0, 5'h0, old);
    check("R10 illegal 111", {31'b0, round_illegal}, 32'h1);
    op(2'd1, 1'b1, 32'h4, 1'b0, 5'h0, old);
    check("R10 legal 100", {31'b0, round_illegal}, 32'h0);
    check("R10 round_mode 100", {29'b0, round_mode}, 32'h4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_swap();
    t_rm_swap();
    t_flag_swap();
    t_read_only();
    t_accrue();
    t_collide();
    t_unused_view();
    t_modes();
    finish_run();
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule